// File: doc/BRIEF.md
# Decimate-by-Two Droop Compensation Filter

This block sits after a fifth-order cascaded integrator-comb decimator and undoes the gradual passband sag that such a stage leaves behind. It is a symmetric, linear-phase 19-tap FIR (order 18) whose response rises toward the band edge, so the two stages together give a flat passband. It also halves the sample rate: it takes every accepted input into its delay line but computes a result only for every second one.

Samples arrive as 26-bit two's complement words qualified by a valid strobe, and may have idle cycles between them. Mirror-image taps are summed before weighting, so only ten constant products are formed. Each product is a sum of signed shifts taken from the canonical-signed-digit form of a fixed integer coefficient. The weighted sum keeps two fractional bits below the 24-bit output LSB. Those two bits are rounded half-up, and the result is clipped to the 24-bit signed range.

Top module: `cic_comp_decim2`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is 0. The delay line is cleared, and the first sample accepted after reset does not produce an output.
- R2: Accepted samples are counted from 0 after reset. Only samples with an odd count (the 2nd, 4th, ...) produce an output. `out_valid` goes high for exactly one cycle, three cycles after the cycle in which that sample is presented, and is never high in two consecutive cycles.
- R3: Let x[0] be the newest accepted sample and x[k] the k-th older one. The output is computed from S = sum over k=0..18 of h[k]*x[k], with h[0]=h[18]=1, h[1]=h[17]=-2, h[2]=h[16]=3, h[3]=h[15]=-6, h[4]=h[14]=9, h[5]=h[13]=-16, h[6]=h[12]=26, h[7]=h[11]=-48, h[8]=h[10]=106, h[9]=878. These sum to 1024, which is unity gain at DC.
- R4: Feed an impulse of 4096 into an otherwise zero stream. If the impulse is the 2nd sample after reset, the outputs are h[0], h[2], ..., h[18]. If it is the 1st sample, the outputs are h[1], h[3], ..., h[17], followed by 0.
- R5: Rounding works in two steps. First g = floor(S/1024), which has two fractional bits. Then out = floor((g+2)/4), so a fraction of exactly one half rounds up. A settled constant input x therefore gives floor((x+2)/4): 6 gives 2, 5 gives 1, -2 gives 0, -3 gives -1, -6 gives -1.
- R6: Results above 8388607 are output as 8388607, and results below -8388608 are output as -8388608.
- R7: Cycles with `in_valid` low change neither the stored samples nor the odd/even count. A stream with gaps gives the same output values as the same samples sent back to back.
- R8: `out_data` changes only in a cycle where `out_valid` is high. Between pulses it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 26 | Input sample, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | 24 | Rounded, saturated output sample, two's complement |

## Verification
The negative clip is the hardest case to reach. A constant input cannot reach it, because the DC gain is exactly one and the most negative input maps exactly onto the most negative output. The bench therefore builds a 19-sample run in which each sample's sign matches the sign of the coefficient it will meet at the chosen output instant. This pushes the weighted sum about 28% past full scale in either direction. A second hard case is gaps that fall on either side of an odd sample. The bench sends the same values once with irregular idle cycles and once without gaps, and requires identical results.

// File: rtl/cicc_pkg.sv
`timescale 1ns/1ps
package cicc_pkg;
  localparam int IN_W       = 26;
  localparam int OUT_W      = 24;
  localparam int TAPS       = 19;
  localparam int GUARD      = 2;
  localparam int COEF_FRAC  = 10;
  localparam int CSD_DIGITS = 14;
  localparam int PAIRS      = (TAPS + 1) / 2;
  localparam int ACC_W      = IN_W + 1 + CSD_DIGITS + $clog2(PAIRS);

  // Fixed half of the symmetric inverse-droop response; index folds about the centre.
  function automatic int tap_coef(input int k);
    int m;
    m = (k <= (TAPS - 1) / 2) ? k : (TAPS - 1 - k);
    case (m)
      0: return 1;
      1: return -2;
      2: return 3;
      3: return -6;
      4: return 9;
      5: return -16;
      6: return 26;
      7: return -48;
      8: return 106;
      9: return 878;
      default: return 0;
    endcase
  endfunction

  // Constant multiply by recoding c into signed digits and adding shifted copies of x.
  function automatic logic signed [ACC_W-1:0] csd_mul(input logic signed [ACC_W-1:0] x,
                                                      input int c);
    logic signed [ACC_W-1:0] sum;
    int rem;
    int dig;
    sum = '0;
    rem = c;
    for (int b = 0; b < CSD_DIGITS; b++) begin
      if ((rem & 1) != 0) begin
        dig = ((rem & 3) == 1) ? 1 : -1;
        if (dig > 0) sum = sum + (x <<< b);
        else         sum = sum - (x <<< b);
        rem = rem - dig;
      end
      rem = rem >>> 1;
    end
    return sum;
  endfunction

  localparam logic signed [ACC_W-1:0] RND_ADD =
    {{(ACC_W-GUARD){1'b0}}, 1'b1, {(GUARD-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] OUT_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN = ~OUT_MAX;

  // Drop coefficient scaling, keep GUARD fraction bits, round half-up, clip.
  function automatic logic [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] g;
    logic signed [ACC_W-1:0] r;
    g = acc >>> COEF_FRAC;
    r = (g + RND_ADD) >>> GUARD;
    if (r > OUT_MAX)      r = OUT_MAX;
    else if (r < OUT_MIN) r = OUT_MIN;
    return r[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/cicc_tap_line.sv
`timescale 1ns/1ps
module cicc_tap_line #(
  parameter int W     = 26,
  parameter int DEPTH = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic [W-1:0]            din,
  output logic [DEPTH-1:0][W-1:0] taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps[0] <= '0;
    else if (shift_en) taps[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[i] <= '0;
      else if (shift_en) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/cicc_fold_weight.sv
`timescale 1ns/1ps
module cicc_fold_weight import cicc_pkg::*; #(
  parameter int W     = IN_W,
  parameter int DEPTH = TAPS,
  parameter int AW    = ACC_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [DEPTH-1:0][W-1:0]           taps,
  output logic [(DEPTH+1)/2-1:0][AW-1:0]    prod,
  output logic                              prod_valid
);
  localparam int NP = (DEPTH + 1) / 2;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic signed [AW-1:0] near_s;
    logic signed [AW-1:0] folded;
    assign near_s = $signed({{(AW-W){taps[p][W-1]}}, taps[p]});
    if ((DEPTH % 2 == 1) && (p == DEPTH / 2)) begin : g_centre
      assign folded = near_s;
    end else begin : g_fold
      logic signed [AW-1:0] far_s;
      assign far_s  = $signed({{(AW-W){taps[DEPTH-1-p][W-1]}}, taps[DEPTH-1-p]});
      assign folded = near_s + far_s;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod[p] <= '0;
      else if (load) prod[p] <= csd_mul(folded, tap_coef(p));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_valid <= 1'b0;
    else        prod_valid <= load;
  end
endmodule

// File: rtl/cicc_round_out.sv
`timescale 1ns/1ps
module cicc_round_out import cicc_pkg::*; #(
  parameter int NP = PAIRS,
  parameter int AW = ACC_W,
  parameter int OW = OUT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NP-1:0][AW-1:0]    prod,
  output logic                     out_valid,
  output logic [OW-1:0]            out_data
);
  logic signed [AW-1:0] total;

  always_comb begin
    total = '0;
    for (int p = 0; p < NP; p++) total = total + $signed(prod[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= load;
      if (load) out_data <= round_sat(total);
    end
  end
endmodule

// File: rtl/cic_comp_decim2.sv
`timescale 1ns/1ps
module cic_comp_decim2 import cicc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic                           phase_q;
  logic                           keep_now;
  logic                           fire_s1;
  logic [TAPS-1:0][IN_W-1:0]      taps;
  logic [PAIRS-1:0][ACC_W-1:0]    prod;
  logic                           prod_valid;

  assign keep_now = in_valid & phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      fire_s1 <= 1'b0;
    end else begin
      if (in_valid) phase_q <= ~phase_q;
      fire_s1 <= keep_now;
    end
  end

  cicc_tap_line #(.W(IN_W), .DEPTH(TAPS)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_data), .taps(taps)
  );

  cicc_fold_weight #(.W(IN_W), .DEPTH(TAPS), .AW(ACC_W)) u_weight (
    .clk(clk), .rst_n(rst_n), .load(fire_s1), .taps(taps),
    .prod(prod), .prod_valid(prod_valid)
  );

  cicc_round_out #(.NP(PAIRS), .AW(ACC_W), .OW(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(prod_valid), .prod(prod),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/cicc_checks.sv
`timescale 1ns/1ps
module cicc_checks #(
  parameter int OW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          phase,
  input logic          mac_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  assert_phase_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (phase != $past(phase)));

  assert_gap_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_out_after_mac_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mac_valid));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);
endmodule

bind cic_comp_decim2 cicc_checks #(.OW(cicc_pkg::OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase_q),
  .mac_valid(prod_valid), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cic_comp_decim2_bench.sv
`timescale 1ns/1ps
module cic_comp_decim2_bench;
  localparam int IW = 26;
  localparam int OW = 24;
  localparam int NT = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IW-1:0] in_data = '0;
  logic out_valid;
  logic [OW-1:0] out_data;

  always #2.5 clk = ~clk;

  cic_comp_decim2 u_cic_comp_decim2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  longint H [NT] = '{1, -2, 3, -6, 9, -16, 26, -48, 106, 878,
                     106, -48, 26, -16, 9, -6, 3, -2, 1};
  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint hist [NT];
  int cnt = 0;
  bit p0v, p1v, p2v;
  longint p0d, p1d, p2d, hold;
  longint got [$];
  longint saved [$];

  task automatic check(input bit ok, input string tag, input longint gv, input longint ev);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, gv, ev);
    end
  endtask

  function automatic longint model_out();
    longint acc, g, r;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += H[k] * hist[k];
    g = acc >>> 10;
    r = (g + 2) >>> 2;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  // Reference: three-stage delay of expected results, updated at each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) hist[k] = 0;
      cnt = 0; p0v = 0; p1v = 0; p2v = 0; hold = 0;
    end else begin
      p2v = p1v; p2d = p1d; p1v = p0v; p1d = p0d; p0v = 0;
      if (in_valid) begin
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(in_data));
        if (cnt % 2 == 1) begin
          p0v = 1;
          p0d = model_out();
        end
        cnt++;
      end
      if (p2v) hold = p2d;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == p2v, "R2 out_valid timing", longint'(out_valid), longint'(p2v));
      if (p2v) check(longint'($signed(out_data)) == hold, "R3 output value",
                     longint'($signed(out_data)), hold);
      else     check(longint'($signed(out_data)) == hold, "R8 hold between pulses",
                     longint'($signed(out_data)), hold);
      if (out_valid) got.push_back(longint'($signed(out_data)));
    end
  end

  task automatic push(input longint x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[IW-1:0];
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    check(out_data == '0, "R1 reset out_data", longint'($signed(out_data)), 0);
    rst_n = 1'b1;
    got.delete();
  endtask

  task automatic dc_case(input longint x, input longint ev, input string tag);
    do_reset();
    for (int i = 0; i < 22; i++) push(x);
    idle(6);
    check(got.size() == 11, {tag, " count"}, got.size(), 11);
    if (got.size() > 0) check(got[got.size()-1] == ev, tag, got[got.size()-1], ev);
  endtask

  task automatic sat_case(input bit pos, input longint ev, input string tag);
    longint x;
    do_reset();
    push(0);
    for (int j = 1; j <= NT; j++) begin
      if ((H[NT-j] > 0) == pos) x = 33554431;
      else                      x = -33554432;
      push(x);
    end
    idle(6);
    check(got.size() == 10, {tag, " count"}, got.size(), 10);
    if (got.size() > 0) check(got[got.size()-1] == ev, tag, got[got.size()-1], ev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R2 watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint seed;
    // R1: first sample after reset yields nothing; R2: second yields one pulse
    do_reset();
    push(1000);
    idle(8);
    check(got.size() == 0, "R1 first sample silent", got.size(), 0);
    push(2000);
    idle(8);
    check(got.size() == 1, "R2 second sample produces one output", got.size(), 1);

    // R4: impulse on the 2nd sample gives even-index coefficients
    do_reset();
    push(0);
    push(4096);
    for (int i = 0; i < NT; i++) push(0);
    idle(6);
    check(got.size() == 10, "R4 impulse count even", got.size(), 10);
    for (int i = 0; i < 10 && i < got.size(); i++)
      check(got[i] == H[2*i], "R4 impulse even taps", got[i], H[2*i]);

    // R4: impulse on the 1st sample gives odd-index coefficients then zero
    do_reset();
    push(4096);
    for (int i = 0; i < NT; i++) push(0);
    idle(6);
    check(got.size() == 10, "R4 impulse count odd", got.size(), 10);
    for (int i = 0; i < 10 && i < got.size(); i++)
      check(got[i] == ((i < 9) ? H[2*i+1] : 0), "R4 impulse odd taps", got[i],
            (i < 9) ? H[2*i+1] : 0);

    // R5: half-up rounding of the two guard bits
    dc_case(6, 2, "R5 dc 6");
    dc_case(5, 1, "R5 dc 5");
    dc_case(-2, 0, "R5 dc -2");
    dc_case(-3, -1, "R5 dc -3");
    dc_case(-6, -1, "R5 dc -6");
    dc_case(33554431, 8388607, "R6 dc max clips");
    dc_case(-33554432, -8388608, "R6 dc min");

    // R6: sign-matched runs overshoot full scale both ways
    sat_case(1'b1, 8388607, "R6 positive clip");
    sat_case(1'b0, -8388608, "R6 negative clip");

    // R7: the same samples with gaps, then back to back
    do_reset();
    for (int i = 0; i < 24; i++) begin
      push(longint'(i * 911 - 7000));
      idle((i % 3) + 1);
    end
    idle(10);
    check(got.size() == 12, "R7 gap output count", got.size(), 12);
    saved = got;
    do_reset();
    for (int i = 0; i < 24; i++) push(longint'(i * 911 - 7000));
    idle(6);
    check(got.size() == saved.size(), "R7 gapless count", got.size(), saved.size());
    for (int i = 0; i < got.size() && i < saved.size(); i++)
      check(got[i] == saved[i], "R7 gaps do not alter values", saved[i], got[i]);
    idle(20);
    check(got.size() == 12, "R7 idle produces nothing", got.size(), 12);

    // R3: pseudo-random samples and strobes against the reference every cycle
    do_reset();
    seed = 12345;
    for (int i = 0; i < 3000; i++) begin
      seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
      if (seed[3:0] < 4'd11) push(longint'($signed(seed[30:5])));
      else idle(1);
    end
    idle(8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule